// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a logical address from a processor into a physical address. The logical address is cut into a virtual page number (upper bits) and a byte offset (lower bits). The page number selects one entry of a single-level page table that lives in main memory. The offset is copied unchanged into the low bits of the result. A small fully associative translation cache sits in front of the table. All of its entries are compared with the page number in the same cycle, and a match gives the frame number without any memory traffic.

On a cache miss the block issues one read of the page-table entry through a simple request/response port. It then either completes the translation and installs the entry in the cache, or reports a fault when the entry is marked not present. Two registers held outside the block are presented as inputs: the table base address and the table length in entries. A page number at or beyond the length faults at once, with no memory read.

The block accepts one request at a time. While a request is in progress `ready` is low. A single-cycle `flush` input empties the cache.

Top module: `pgx_xlat`

## Requirements
- R1: The page size `PAGE_BYTES` is a power-of-two parameter between 512 and 8192. The offset is the low log2(PAGE_BYTES) bits of `req_vaddr`, and on success `paddr` = {frame number, offset}.
- R2: When a request is accepted and its page number is greater than or equal to `ptlen`, `fault` pulses in the next cycle. `mem_req` stays low and `done` stays low.
- R3: When an in-range page number matches a valid cache entry, `done` pulses in the cycle after acceptance with the cached frame. No memory read is made.
- R4: On an in-range miss, `mem_req` is a single-cycle pulse in the cycle after acceptance, and `mem_addr` = `ptbase` + page number × 4. Each miss makes exactly one read.
- R5: A page-table entry has its present flag at bit 31 and the frame number in bits [FRAME_W-1:0]. If the flag is 1, `done` pulses in the cycle after `mem_rvalid`, `paddr` holds the new frame, and the entry is installed in the cache.
- R6: If the returned entry has bit 31 = 0, `fault` pulses in the cycle after `mem_rvalid` and nothing is installed. A repeated access to that page reads memory again.
- R7: Installs use round-robin replacement. The victim pointer starts at entry 0 after reset, advances by one on each install, wraps after the last entry, and is not moved by `flush`.
- R8: A one-cycle `flush` invalidates every cache entry. A request accepted in the same cycle as `flush` is handled as a miss.
- R9: Requests are accepted only while `ready` is high, and `ready` is high exactly when no translation is in progress. A `req_valid` seen while `ready` is low has no effect. `done` and `fault` are never high together. After reset, `ready` is 1 and `done`, `fault` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | VA_W | Logical address to translate |
| ptbase | input | PA_W | Physical address of page-table entry 0 |
| ptlen | input | VPN_W+1 | Number of entries in the page table |
| ready | output | 1 | Idle; a request may be accepted |
| done | output | 1 | One-cycle pulse: `paddr` is valid |
| fault | output | 1 | One-cycle pulse: translation refused |
| paddr | output | PA_W | Translated physical address |
| mem_req | output | 1 | One-cycle page-table read request |
| mem_addr | output | PA_W | Page-table entry address |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Page-table entry read from memory |

## Verification
The bound checker watches, on every cycle, the properties that can be read at the ports:
- an out-of-range request faults with no memory read;
- `mem_req` is a single pulse;
- a request accepted together with `flush` reads memory;
- the returned entry's present flag decides between `done` and `fault`, and the frame lands in `paddr`;
- `done` and `fault` never coincide.

The other behaviours depend on the cache contents, so only the bench's scenarios can show them. These are hit versus miss after earlier fills, round-robin eviction order, a flush that clears the cache while the victim pointer keeps its place, a fault that leaves nothing installed, and requests ignored while busy. The bench tracks these with its own model of cache contents and victim pointer, and counts memory reads per request.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int PTE_W         = 32;
  localparam int PTE_VALID_BIT = 31;
  localparam int PTE_BYTES     = 4;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } walk_st_t;
endpackage

// File: rtl/pgx_range.sv
module pgx_range #(
  parameter int VPN_W = 20,
  parameter int PA_W  = 32
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PA_W-1:0]  ptbase,
  input  logic [VPN_W:0]   ptlen,
  output logic             in_range,
  output logic [PA_W-1:0]  pte_addr
);
  localparam int SCALE_W = VPN_W + 2;

  logic [SCALE_W-1:0] scaled;

  always_comb begin
    in_range = ({1'b0, vpn} < ptlen);
    scaled   = {vpn, 2'b00};
    pte_addr = ptbase + PA_W'(scaled);
  end
endmodule

// File: rtl/pgx_tlb.sv
module pgx_tlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_en,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [FRAME_W-1:0] fill_frame
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [VPN_W-1:0]   tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   victim_q;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = valid_q[g] && (tag_q[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_hit   = |match;
    lk_frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_frame = lk_frame | frame_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      victim_q <= '0;
    end else if (flush) begin
      valid_q  <= '0;
    end else if (fill_en) begin
      valid_q[victim_q] <= 1'b1;
      victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en && !flush) begin
      tag_q[victim_q]   <= fill_vpn;
      frame_q[victim_q] <= fill_frame;
    end
  end
endmodule

// File: rtl/pgx_xlat.sv
module pgx_xlat
  import pgx_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_BYTES = 4096,
  parameter int ENTRIES    = 4,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VA_W - OFF_W,
  localparam int FRAME_W   = PA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [PA_W-1:0]   ptbase,
  input  logic [VPN_W:0]    ptlen,
  output logic              ready,
  output logic              done,
  output logic              fault,
  output logic [PA_W-1:0]   paddr,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [PTE_W-1:0]  mem_rdata
);
  walk_st_t           st_q;
  logic [VPN_W-1:0]   vpn_in;
  logic [OFF_W-1:0]   off_in;
  logic [VPN_W-1:0]   vpn_q;
  logic [OFF_W-1:0]   off_q;
  logic               in_range;
  logic [PA_W-1:0]    pte_addr;
  logic               tlb_hit;
  logic [FRAME_W-1:0] tlb_frame;
  logic               hit_eff;
  logic               pte_ok;
  logic               fill_en;

  assign vpn_in  = req_vaddr[VA_W-1:OFF_W];
  assign off_in  = req_vaddr[OFF_W-1:0];
  assign ready   = (st_q == ST_IDLE);
  assign hit_eff = tlb_hit && !flush;
  assign pte_ok  = mem_rdata[PTE_VALID_BIT];
  assign fill_en = (st_q == ST_WAIT) && mem_rvalid && pte_ok;

  pgx_range #(.VPN_W(VPN_W), .PA_W(PA_W)) u_range (
    .vpn      (vpn_in),
    .ptbase   (ptbase),
    .ptlen    (ptlen),
    .in_range (in_range),
    .pte_addr (pte_addr)
  );

  pgx_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_tlb (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .lk_vpn     (vpn_in),
    .lk_hit     (tlb_hit),
    .lk_frame   (tlb_frame),
    .fill_en    (fill_en),
    .fill_vpn   (vpn_q),
    .fill_frame (mem_rdata[FRAME_W-1:0])
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      done     <= 1'b0;
      fault    <= 1'b0;
      mem_req  <= 1'b0;
      paddr    <= '0;
      mem_addr <= '0;
      vpn_q    <= '0;
      off_q    <= '0;
    end else begin
      done    <= 1'b0;
      fault   <= 1'b0;
      mem_req <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q <= vpn_in;
            off_q <= off_in;
            if (!in_range) begin
              fault <= 1'b1;
            end else if (hit_eff) begin
              done  <= 1'b1;
              paddr <= {tlb_frame, off_in};
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= pte_addr;
              st_q     <= ST_WAIT;
            end
          end
        end
        default: begin
          if (mem_rvalid) begin
            st_q <= ST_IDLE;
            if (pte_ok) begin
              done  <= 1'b1;
              paddr <= {mem_rdata[FRAME_W-1:0], off_q};
            end else begin
              fault <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pgx_xlat_chk.sv
module pgx_xlat_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            flush,
  input logic            req_valid,
  input logic [VA_W-1:0] req_vaddr,
  input logic [VPN_W:0]  ptlen,
  input logic            ready,
  input logic            done,
  input logic            fault,
  input logic [PA_W-1:0] paddr,
  input logic            mem_req,
  input logic            mem_rvalid,
  input logic [31:0]     mem_rdata
);
  logic out_of_range;
  assign out_of_range = ({1'b0, req_vaddr[VA_W-1:OFF_W]} >= ptlen);

  p_len_fault_r2: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && out_of_range) |=> (fault && !done && !mem_req));

  p_mem_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> (!mem_req && !ready));

  p_pte_done_r5: assert property (@(posedge clk) disable iff (rst)
    (!ready && mem_rvalid && mem_rdata[31]) |=>
      (done && paddr[PA_W-1:OFF_W] == $past(mem_rdata[FRAME_W-1:0])));

  p_pte_fault_r6: assert property (@(posedge clk) disable iff (rst)
    (!ready && mem_rvalid && !mem_rdata[31]) |=> (fault && !done));

  p_flush_miss_r8: assert property (@(posedge clk) disable iff (rst)
    (ready && req_valid && flush && !out_of_range) |=> mem_req);

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && fault));
endmodule

bind pgx_xlat pgx_xlat_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .VPN_W(VPN_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
  .req_vaddr(req_vaddr), .ptlen(ptlen), .ready(ready), .done(done),
  .fault(fault), .paddr(paddr), .mem_req(mem_req),
  .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/pgx_xlat_test.sv
module pgx_xlat_test;
  localparam int CLK_NS     = 10;
  localparam int VA_W       = 32;
  localparam int PA_W       = 32;
  localparam int PAGE_BYTES = 4096;
  localparam int ENTRIES    = 4;
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int VPN_W      = VA_W - OFF_W;
  localparam int FRAME_W    = PA_W - OFF_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              flush = 1'b0;
  logic              req_valid = 1'b0;
  logic [VA_W-1:0]   req_vaddr = '0;
  logic [PA_W-1:0]   ptbase = '0;
  logic [VPN_W:0]    ptlen = '0;
  logic              ready, done, fault, mem_req;
  logic [PA_W-1:0]   paddr, mem_addr;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = '0;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  logic [VPN_W-1:0]   m_tag [ENTRIES];
  logic [FRAME_W-1:0] m_frm [ENTRIES];
  bit                 m_val [ENTRIES];
  int                 m_ptr = 0;

  pgx_xlat #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BYTES(PAGE_BYTES), .ENTRIES(ENTRIES)) uut (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .ptbase(ptbase), .ptlen(ptlen), .ready(ready),
    .done(done), .fault(fault), .paddr(paddr), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pte_of(input logic [PA_W-1:0] pa, input logic [PA_W-1:0] base);
    logic [31:0] r;
    logic [VPN_W-1:0] v;
    v = VPN_W'((pa - base) >> 2);
    r = '0;
    r[FRAME_W-1:0] = FRAME_W'(v * 13 + 5 + base[15:8]);
    r[31] = ((v % 7) != 3);
    return r;
  endfunction

  task automatic model_flush();
    for (int i = 0; i < ENTRIES; i++) m_val[i] = 0;
  endtask

  task automatic xlat(input logic [VA_W-1:0] va, input bit with_flush, input bit poke);
    logic [VPN_W-1:0] vpn;
    logic [OFF_W-1:0] off;
    logic [31:0] pte;
    logic [PA_W-1:0] exp_addr;
    int kind;
    int hit_i;
    int cycles;
    int reads;
    bit got_done, got_fault;
    logic [PA_W-1:0] got_pa;
    vpn = va[VA_W-1:OFF_W];
    off = va[OFF_W-1:0];
    if (with_flush) model_flush();
    hit_i = -1;
    for (int i = 0; i < ENTRIES; i++) if (m_val[i] && m_tag[i] == vpn) hit_i = i;
    if ({1'b0, vpn} >= ptlen) kind = 0;
    else if (hit_i >= 0) kind = 1;
    else kind = 2;
    exp_addr = ptbase + PA_W'({vpn, 2'b00});
    pte = pte_of(exp_addr, ptbase);

    @(negedge clk);
    check(ready == 1'b1, "R9", "ready before request", 64'(ready), 64'd1);
    req_valid = 1'b1;
    req_vaddr = va;
    flush = with_flush;
    @(negedge clk);
    req_valid = 1'b0;
    flush = 1'b0;
    cycles = 1;
    reads = 0;
    while (!(done || fault) && cycles < 40) begin
      if (mem_req) begin
        reads++;
        check(mem_addr == exp_addr, "R4", "table entry address", 64'(mem_addr), 64'(exp_addr));
        if (poke) begin
          req_valid = 1'b1;
          req_vaddr = {VPN_W'(9999), OFF_W'(0)};
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(mem_req == 1'b0, "R4", "read request lasts one cycle", 64'(mem_req), 64'd0);
        mem_rvalid = 1'b1;
        mem_rdata = pte_of(mem_addr, ptbase);
        @(negedge clk);
        mem_rvalid = 1'b0;
        cycles += 2;
      end else begin
        @(negedge clk);
        cycles++;
      end
    end
    got_done = done;
    got_fault = fault;
    got_pa = paddr;

    case (kind)
      0: begin
        check(got_fault && !got_done && cycles == 1, "R2", "range fault next cycle",
              64'({got_fault, got_done}), 64'b10);
        check(reads == 0, "R2", "no read on range fault", 64'(reads), 64'd0);
      end
      1: begin
        check(got_done && !got_fault && cycles == 1, "R3", "hit completes next cycle",
              64'({got_done, 8'(cycles)}), 64'({1'b1, 8'd1}));
        check(reads == 0, "R3", "no read on hit", 64'(reads), 64'd0);
        check(got_pa == {m_frm[hit_i], off}, "R1", "paddr from cached frame",
              64'(got_pa), 64'({m_frm[hit_i], off}));
      end
      default: begin
        check(reads == 1, "R4", "one read per miss", 64'(reads), 64'd1);
        if (pte[31]) begin
          check(got_done && !got_fault, "R5", "present entry completes",
                64'({got_done, got_fault}), 64'b10);
          check(got_pa == {pte[FRAME_W-1:0], off}, "R1", "paddr from table frame",
                64'(got_pa), 64'({pte[FRAME_W-1:0], off}));
          m_tag[m_ptr] = vpn;
          m_frm[m_ptr] = pte[FRAME_W-1:0];
          m_val[m_ptr] = 1;
          m_ptr = (m_ptr + 1) % ENTRIES;
        end else begin
          check(got_fault && !got_done, "R6", "absent entry faults",
                64'({got_fault, got_done}), 64'b10);
        end
      end
    endcase
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      check(!done && !fault && !mem_req, "R9", "no stray activity after request",
            64'({done, fault, mem_req}), 64'd0);
    end
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    model_flush();
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    model_flush();
    ptbase = 32'h0001_0000;
    ptlen  = 21'd40;
    repeat (3) @(negedge clk);
    check(ready && !done && !fault && !mem_req, "R9", "reset state",
          64'({ready, done, fault, mem_req}), 64'b1000);
    rst = 1'b0;

    xlat({20'd2, 12'h123}, 0, 0);   // R4 R5 miss then fill
    xlat({20'd2, 12'hABC}, 0, 0);   // R3 hit
    xlat({20'd3, 12'h001}, 0, 0);   // R6 absent entry
    xlat({20'd3, 12'h002}, 0, 0);   // R6 walks again, nothing installed
    xlat({20'd40, 12'h000}, 0, 0);  // R2 first out-of-range page
    xlat({20'd39, 12'hFFF}, 0, 0);  // R2 last in-range page
    xlat({20'd20, 12'h010}, 0, 1);  // R9 request ignored while busy
    // R7 round-robin eviction: five fills on four entries
    do_flush();                     // R8
    xlat({20'd2, 12'h000}, 0, 0);   // R8 miss after flush
    xlat({20'd5, 12'h000}, 0, 0);
    xlat({20'd6, 12'h000}, 0, 0);
    xlat({20'd8, 12'h000}, 0, 0);
    xlat({20'd9, 12'h000}, 0, 0);   // R7 evicts the oldest fill
    xlat({20'd6, 12'h444}, 0, 0);   // R7 survivor hits
    xlat({20'd2, 12'h555}, 0, 0);   // R7 evicted page misses
    xlat({20'd8, 12'h666}, 0, 1'b0);
    xlat({20'd8, 12'h777}, 1, 0);   // R8 flush with request forces a miss

    ptbase = 32'h0002_0400;
    do_flush();
    for (int it = 0; it < 400; it++) begin
      logic [VA_W-1:0] va;
      va = {VPN_W'($urandom % 48), OFF_W'($urandom)};
      if (it % 37 == 36) do_flush();
      xlat(va, (it % 29 == 11), (it % 17 == 5));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule